// File: doc/BRIEF.md
# NOR Flash Command Sequencer (dual 16-bit devices)

This block is a bus master that drives a 32-bit memory bus on which two 16-bit NOR flash devices sit side by side, one per halfword lane. A client hands it one request at a time: read the identification codes, program one word, or erase a range of sectors. The sequencer sends the unlock and command write cycles with the command byte copied into both lanes. It then polls the status flag bits of both devices until both report completion or a cycle-count timeout runs out, and it returns a two-bit result code.

Bus addresses are word offsets from the bank base, which is offset 0. Sector `n` starts at word `n * SECT_WORDS`. Each sector has one bit in `protect_mask`, and a set bit keeps that sector from being erased. Result codes are 0 = success, 1 = timeout or rejected request, and 2 = destination not erased.

States are IDLE, PCHK (program pre-read), UNL_A / UNL_B (first unlock pair), CMD (command write), ER_A / ER_B (second unlock pair for erase), SECT (sector erase writes), SETTLE (fixed wait), EPOLL (erase poll), PWR (program data write), PPOLL (program poll), ID_M / ID_D (identification reads), RST (read-mode reset write) and DONE.

The transitions are:
- IDLE to PCHK, UNL_A or DONE when a request is accepted.
- PCHK to UNL_A, or to DONE on code 2.
- UNL_A to UNL_B to CMD.
- CMD to ER_A, PWR or ID_M, depending on the operation.
- ER_A to ER_B to SECT.
- SECT to SETTLE if at least one sector was erased, otherwise to RST.
- SETTLE to EPOLL.
- EPOLL to RST on completion, or to DONE on timeout.
- PWR to PPOLL, then PPOLL to DONE.
- ID_M to ID_D to DONE.
- RST to DONE, and DONE to IDLE.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are 0 and `status` is 0.
- R2: Every command write carries its command byte in bits 7:0 and again in bits 23:16, with all other bits zero (for example AA is sent as 0x00AA00AA).
- R3: Every unlock pair is a write of AA at word 0x555 followed by a write of 55 at word 0x2AA.
- R4: Identification (`req_op`=0) sends the unlock pair, then 90 at 0x555. It then reads word 0 into `id_manuf` and word 1 into `id_dev`, and returns code 0.
- R5: Program (`req_op`=1) first reads the destination. If (read AND new data) is not equal to the new data, it returns code 2 and makes no write cycle.
- R6: Otherwise program sends the unlock pair, A0 at 0x555, and the data word at the destination. It then rereads the destination until bits 23 and 7 equal those bits of the data, and returns code 0.
- R7: If the program poll has not matched when `PROG_TO` cycles have elapsed, the result is code 1.
- R8: Erase (`req_op`=2) sends the unlock pair, 80 at 0x555 and a second unlock pair. It then writes 30 at the start word of each sector from first to last in ascending order, skipping every sector whose `protect_mask` bit is set.
- R9: At least `SETTLE_CYC` cycles after the last sector write, erase polls the start word of the last erased sector until bits 23 and 7 are both 1. It then writes F0 at word 0 and returns code 0.
- R10: An erase in which every requested sector is protected makes no sector write and no poll. It writes F0 at word 0 and returns code 0.
- R11: If the erase poll has not completed within `ERASE_TO` cycles, the result is code 1 and no F0 write is made.
- R12: An erase with first < 0, first > last or last >= `NSECT` returns code 1 with no bus cycle.
- R13: `busy` is 1 from the cycle after acceptance until the result, and `done` is a one-cycle pulse. A request raised while busy is ignored.
- R14: Once `bus_req` is raised, it stays high with `bus_we`, `bus_addr` and `bus_wdata` unchanged until the cycle in which `bus_ack` is seen. Only one access is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| req_valid | input | 1 | request strobe, taken when idle |
| req_op | input | 2 | 0 identify, 1 program, 2 erase |
| req_addr | input | AW | program destination word |
| req_data | input | 32 | program data |
| req_first | input | SXW | first sector of erase (signed) |
| req_last | input | SXW | last sector of erase (signed) |
| protect_mask | input | NSECT | one protect bit per sector |
| busy | output | 1 | operation in progress |
| done | output | 1 | one-cycle completion pulse |
| status | output | 2 | result code, valid with `done` |
| id_manuf | output | 32 | manufacturer code read |
| id_dev | output | 32 | device code read |
| bus_req | output | 1 | bus access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | word address |
| bus_wdata | output | 32 | write data |
| bus_ack | input | 1 | access complete, read data valid |
| bus_rdata | input | 32 | read data |

## Verification
Each bus access finishes in the cycle in which `bus_ack` is seen, and the next access can start in the following cycle. The result appears as `done` exactly one cycle after the acknowledge of the final access. An erase range that is rejected produces `done` one cycle after acceptance.

The bench's responder acknowledges every request one cycle after seeing it and records each access together with the cycle number. The bench then waits for `done` at falling edges, reads `status` in that same half-cycle, and compares the recorded access list with the sequence it expects. The settling gap is measured from the recorded cycle numbers of the last sector write and the first poll.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
    localparam int LANE_W   = 16;
    localparam int LANES    = 2;
    localparam int DW       = LANE_W * LANES;
    localparam int FLAG_BIT = 7;

    localparam logic [1:0] OP_IDENT = 2'd0;
    localparam logic [1:0] OP_PROG  = 2'd1;
    localparam logic [1:0] OP_ERASE = 2'd2;

    localparam logic [1:0] RC_OK    = 2'd0;
    localparam logic [1:0] RC_FAIL  = 2'd1;
    localparam logic [1:0] RC_DIRTY = 2'd2;

    localparam logic [7:0] CMD_KEY_A = 8'hAA;
    localparam logic [7:0] CMD_KEY_B = 8'h55;
    localparam logic [7:0] CMD_IDENT = 8'h90;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_ERASE = 8'h80;
    localparam logic [7:0] CMD_SECT  = 8'h30;
    localparam logic [7:0] CMD_RDMD  = 8'hF0;

    localparam int OFS_KEY_A = 'h555;
    localparam int OFS_KEY_B = 'h2AA;

    // copy one command byte into the low byte of every halfword lane
    function automatic logic [DW-1:0] lane_rep(input logic [7:0] b);
        logic [DW-1:0] r;
        r = '0;
        for (int l = 0; l < LANES; l++) r[l*LANE_W +: 8] = b;
        return r;
    endfunction
endpackage

// File: rtl/nor_seq_timer.sv
module nor_seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R9: an expired counter stays expired until reloaded
    a_r9_timer_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |=> cnt_q == '0);
endmodule

// File: rtl/nor_poll_match.sv
module nor_poll_match #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] rd_flag,
    input  logic [LANES-1:0] ref_flag,
    input  logic             need_set,
    output logic             hit
);
    logic [LANES-1:0] lane_ok;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_ok[l] = need_set ? rd_flag[l] : (rd_flag[l] == ref_flag[l]);
    end

    assign hit = &lane_ok;
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW         = 12,
    parameter int NSECT      = 8,
    parameter int SECT_WORDS = 64,
    parameter int SETTLE_CYC = 100,
    parameter int PROG_TO    = 400,
    parameter int ERASE_TO   = 5000,
    localparam int SXW       = $clog2(NSECT) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic [AW-1:0]         req_addr,
    input  logic [DW-1:0]         req_data,
    input  logic signed [SXW-1:0] req_first,
    input  logic signed [SXW-1:0] req_last,
    input  logic [NSECT-1:0]      protect_mask,
    output logic                  busy,
    output logic                  done,
    output logic [1:0]            status,
    output logic [DW-1:0]         id_manuf,
    output logic [DW-1:0]         id_dev,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic [AW-1:0]         bus_addr,
    output logic [DW-1:0]         bus_wdata,
    input  logic                  bus_ack,
    input  logic [DW-1:0]         bus_rdata
);
    localparam int SIX     = $clog2(NSECT);
    localparam int SECT_SH = $clog2(SECT_WORDS);
    localparam int TMAX    = SETTLE_CYC + PROG_TO + ERASE_TO;
    localparam int TW      = $clog2(TMAX + 1) + 1;

    typedef enum logic [3:0] {
        S_IDLE, S_PCHK, S_UNL_A, S_UNL_B, S_CMD, S_ER_A, S_ER_B, S_SECT,
        S_SETTLE, S_EPOLL, S_PWR, S_PPOLL, S_ID_M, S_ID_D, S_RST, S_DONE
    } state_e;

    state_e         state_q, state_d;
    logic [1:0]     op_q;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  data_q;
    logic [SXW-1:0] cur_q, last_q;
    logic [SIX-1:0] lst_er_q;
    logic           any_q;
    logic [NSECT-1:0] prot_q;
    logic [1:0]     status_q;
    logic [DW-1:0]  idm_q, idd_q;

    logic           ack, dirty, cur_past, range_bad, poll_hit, tmr_zero, tmr_load;
    logic [TW-1:0]  tmr_val;
    logic [SIX-1:0] cur_idx;
    logic [LANES-1:0] rd_flag, ref_flag;

    assign ack       = bus_req && bus_ack;
    assign dirty     = (bus_rdata & data_q) != data_q;
    assign cur_past  = cur_q > last_q;
    assign cur_idx   = cur_q[SIX-1:0];
    assign range_bad = (int'(req_first) < 0) || (int'(req_first) > int'(req_last))
                     || (int'(req_last) >= NSECT);

    for (genvar l = 0; l < LANES; l++) begin : g_flag
        assign rd_flag[l]  = bus_rdata[l*LANE_W + FLAG_BIT];
        assign ref_flag[l] = data_q[l*LANE_W + FLAG_BIT];
    end

    nor_poll_match #(.LANES(LANES)) u_match (
        .rd_flag (rd_flag),
        .ref_flag(ref_flag),
        .need_set(state_q == S_EPOLL),
        .hit     (poll_hit)
    );

    nor_seq_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    // next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_IDLE: if (req_valid) begin
                if (req_op == OP_PROG)                     state_d = S_PCHK;
                else if (req_op == OP_IDENT)               state_d = S_UNL_A;
                else if (req_op == OP_ERASE && !range_bad) state_d = S_UNL_A;
                else                                       state_d = S_DONE;
            end
            S_PCHK:  if (ack) state_d = dirty ? S_DONE : S_UNL_A;
            S_UNL_A: if (ack) state_d = S_UNL_B;
            S_UNL_B: if (ack) state_d = S_CMD;
            S_CMD:   if (ack) begin
                if (op_q == OP_ERASE)     state_d = S_ER_A;
                else if (op_q == OP_PROG) state_d = S_PWR;
                else                      state_d = S_ID_M;
            end
            S_ER_A:  if (ack) state_d = S_ER_B;
            S_ER_B:  if (ack) state_d = S_SECT;
            S_SECT:  if (cur_past) begin
                if (any_q) begin
                    state_d  = S_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETTLE_CYC);
                end else begin
                    state_d  = S_RST;
                end
            end
            S_SETTLE: if (tmr_zero) begin
                state_d  = S_EPOLL;
                tmr_load = 1'b1;
                tmr_val  = TW'(ERASE_TO);
            end
            S_EPOLL: if (ack) begin
                if (poll_hit)      state_d = S_RST;
                else if (tmr_zero) state_d = S_DONE;
            end
            S_PWR: if (ack) begin
                state_d  = S_PPOLL;
                tmr_load = 1'b1;
                tmr_val  = TW'(PROG_TO);
            end
            S_PPOLL: if (ack && (poll_hit || tmr_zero)) state_d = S_DONE;
            S_ID_M:  if (ack) state_d = S_ID_D;
            S_ID_D:  if (ack) state_d = S_DONE;
            S_RST:   if (ack) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            op_q     <= OP_IDENT;
            addr_q   <= '0;
            data_q   <= '0;
            cur_q    <= '0;
            last_q   <= '0;
            lst_er_q <= '0;
            any_q    <= 1'b0;
            prot_q   <= '0;
            status_q <= RC_OK;
            idm_q    <= '0;
            idd_q    <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    op_q     <= req_op;
                    addr_q   <= req_addr;
                    data_q   <= req_data;
                    cur_q    <= req_first;
                    last_q   <= req_last;
                    any_q    <= 1'b0;
                    prot_q   <= protect_mask;
                    status_q <= ((req_op == OP_ERASE && range_bad) || req_op == 2'd3)
                                ? RC_FAIL : RC_OK;
                end
                S_PCHK: if (ack && dirty) status_q <= RC_DIRTY;
                S_SECT: if (!cur_past && (prot_q[cur_idx] || ack)) begin
                    cur_q <= cur_q + 1'b1;
                    if (!prot_q[cur_idx]) begin
                        lst_er_q <= cur_idx;
                        any_q    <= 1'b1;
                    end
                end
                S_EPOLL, S_PPOLL: if (ack && !poll_hit && tmr_zero) status_q <= RC_FAIL;
                S_ID_M: if (ack) idm_q <= bus_rdata;
                S_ID_D: if (ack) idd_q <= bus_rdata;
                default: ;
            endcase
        end
    end

    // bus and handshake outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state_q)
            S_PCHK, S_PPOLL: begin
                bus_req  = 1'b1;
                bus_addr = addr_q;
            end
            S_UNL_A, S_ER_A: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = AW'(OFS_KEY_A); bus_wdata = lane_rep(CMD_KEY_A);
            end
            S_UNL_B, S_ER_B: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = AW'(OFS_KEY_B); bus_wdata = lane_rep(CMD_KEY_B);
            end
            S_CMD: begin
                bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(OFS_KEY_A);
                bus_wdata = lane_rep((op_q == OP_ERASE) ? CMD_ERASE :
                                     (op_q == OP_PROG)  ? CMD_PROG  : CMD_IDENT);
            end
            S_SECT: if (!cur_past && !prot_q[cur_idx]) begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr  = {{(AW-SIX){1'b0}}, cur_idx} << SECT_SH;
                bus_wdata = lane_rep(CMD_SECT);
            end
            S_EPOLL: begin
                bus_req  = 1'b1;
                bus_addr = {{(AW-SIX){1'b0}}, lst_er_q} << SECT_SH;
            end
            S_PWR: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_addr = addr_q; bus_wdata = data_q;
            end
            S_ID_M: bus_req = 1'b1;
            S_ID_D: begin
                bus_req  = 1'b1;
                bus_addr = AW'(1);
            end
            S_RST: begin
                bus_req = 1'b1; bus_we = 1'b1;
                bus_wdata = lane_rep(CMD_RDMD);
            end
            S_IDLE, S_SETTLE, S_DONE: ;
            default: ;
        endcase
    end

    assign busy     = (state_q != S_IDLE) && (state_q != S_DONE);
    assign done     = (state_q == S_DONE);
    assign status   = status_q;
    assign id_manuf = idm_q;
    assign id_dev   = idd_q;

    // R14: request and its payload hold until acknowledged
    a_r14_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)
                                   && $stable(bus_wdata)));
    // R13: no bus traffic while not busy; done is a single pulse
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: command writes carry identical lanes
    a_r2_lane_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && state_q != S_PWR)
        |-> bus_wdata[2*LANE_W-1:LANE_W] == bus_wdata[LANE_W-1:0]);
    // R8: a sector write never targets a protected sector
    a_r8_skip_protected: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SECT && bus_req) |-> !prot_q[bus_addr[SECT_SH +: SIX]]);
    // R5: a dirty destination ends the program with code 2 and no write
    a_r5_dirty_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PCHK && bus_ack && dirty) |=> (done && status == RC_DIRTY && !bus_req));
endmodule

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
    localparam int CLK_NS = 10;
    localparam int AW = 12, NS = 8, SW = 64;
    localparam int SETTLE = 20, PTO = 40, ETO = 60;
    localparam int SXW = $clog2(NS) + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic signed [SXW-1:0] req_first = '0, req_last = '0;
    logic [NS-1:0] protect_mask = '0;
    logic busy, done, bus_req, bus_we;
    logic [1:0] status;
    logic [31:0] id_manuf, id_dev, bus_wdata;
    logic [AW-1:0] bus_addr;
    logic bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    nor_cmd_seq #(.AW(AW), .NSECT(NS), .SECT_WORDS(SW), .SETTLE_CYC(SETTLE),
                  .PROG_TO(PTO), .ERASE_TO(ETO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_first(req_first),
        .req_last(req_last), .protect_mask(protect_mask), .busy(busy), .done(done),
        .status(status), .id_manuf(id_manuf), .id_dev(id_dev), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata));

    initial forever #(CLK_NS/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    // responder: response k of a run is first / busy / final value
    logic [31:0] rsp_first, rsp_busy, rsp_final;
    int rsp_nbusy = 0, rd_k = 0;
    logic        tr_we   [64];
    logic [AW-1:0] tr_addr [64];
    logic [31:0] tr_data [64];
    int          tr_cyc  [64];
    int          tr_n = 0;

    initial begin
        forever begin
            @(posedge clk); #1;
            if (bus_ack) bus_ack = 1'b0;
            else if (bus_req) begin
                if (tr_n < 64) begin
                    tr_we[tr_n] = bus_we; tr_addr[tr_n] = bus_addr;
                    tr_data[tr_n] = bus_wdata; tr_cyc[tr_n] = cyc;
                    tr_n++;
                end
                if (!bus_we) begin
                    bus_rdata = (rd_k == 0) ? rsp_first :
                                (rd_k <= rsp_nbusy) ? rsp_busy : rsp_final;
                    rd_k++;
                end
                bus_ack = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_tr(input int i, input logic we, input logic [AW-1:0] a,
                          input logic [31:0] d, input string tag);
        logic ok;
        ok = (i < tr_n) && tr_we[i] == we && tr_addr[i] == a && (!we || tr_data[i] == d);
        chk(ok, tag, (i < tr_n) ? {tr_we[i] ? 4'h1 : 4'h0, 8'h0, 20'(tr_addr[i])} : 32'hDEAD,
            {we ? 4'h1 : 4'h0, 8'h0, 20'(a)});
        if (we && i < tr_n) chk(tr_data[i] == d, tag, tr_data[i], d);
    endtask

    function automatic int n_writes();
        int n = 0;
        for (int i = 0; i < tr_n; i++) if (tr_we[i]) n++;
        return n;
    endfunction

    logic [1:0] st;

    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [31:0] d, input int f, input int l,
                          input logic [NS-1:0] pm, input bit check_busy);
        int g = 0;
        tr_n = 0; rd_k = 0;
        @(negedge clk);
        req_op = op; req_addr = a; req_data = d;
        req_first = SXW'(f); req_last = SXW'(l); protect_mask = pm;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (check_busy) chk(busy == 1'b1, "R13 busy after accept", 32'(busy), 1);
        while (!done && g < 20000) begin @(negedge clk); g++; end
        st = status;
        @(negedge clk);
    endtask

    localparam logic [85:0] PV [5] = '{
        {12'h040, 32'hFFFFFFFF, 32'h12345678, 8'd2,   2'd0},
        {12'h123, 32'h0000FFFF, 32'h00010001, 8'd0,   2'd2},
        {12'h1FF, 32'hF0F0F0F0, 32'h00F000F0, 8'd3,   2'd0},
        {12'h080, 32'hFFFFFFFF, 32'hA5A5A5A5, 8'd200, 2'd1},
        {12'h001, 32'h00000000, 32'h00000000, 8'd0,   2'd0}
    };

    initial begin
        rsp_first = '0; rsp_busy = '0; rsp_final = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && bus_req == 0, "R1 outputs idle", {busy, done, bus_req}, 0);
        chk(status == 0, "R1 status", 32'(status), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // program vectors (R5 R6 R7)
        for (int i = 0; i < 5; i++) begin
            logic [85:0] v;
            logic [AW-1:0] dst; logic [31:0] cur, dat; int nb; logic [1:0] ex;
            v = PV[i];
            dst = v[85:74]; cur = v[73:42]; dat = v[41:10]; nb = int'(v[9:2]); ex = v[1:0];
            rsp_first = cur; rsp_busy = dat ^ 32'h00800080; rsp_final = dat; rsp_nbusy = nb;
            run_op(2'd1, dst, dat, 0, 0, '0, 1'b1);
            chk(st == ex, "R6/R5/R7 program status", 32'(st), 32'(ex));
            chk_tr(0, 1'b0, dst, '0, "R5 pre-read of destination");
            if (ex == 2'd2) begin
                chk(n_writes() == 0, "R5 no write when not erased", n_writes(), 0);
            end else begin
                chk_tr(1, 1'b1, 12'h555, 32'h00AA00AA, "R3 unlock first");
                chk_tr(2, 1'b1, 12'h2AA, 32'h00550055, "R3 unlock second");
                chk_tr(3, 1'b1, 12'h555, 32'h00A000A0, "R6 program command");
                chk_tr(4, 1'b1, dst, dat, "R6 data write");
                if (ex == 2'd0)
                    chk(tr_n == 6 + nb, "R6 poll count", tr_n, 6 + nb);
                else
                    chk(n_writes() == 4, "R7 timeout write count", n_writes(), 4);
            end
        end

        // R4 identification with R2 lane copy
        rsp_first = 32'h00010001; rsp_nbusy = 0; rsp_final = 32'h22F622F6;
        run_op(2'd0, '0, '0, 0, 0, '0, 1'b0);
        chk(st == 0, "R4 ident status", 32'(st), 0);
        chk_tr(0, 1'b1, 12'h555, 32'h00AA00AA, "R2 R3 replicated key");
        chk_tr(2, 1'b1, 12'h555, 32'h00900090, "R4 ident command");
        chk_tr(3, 1'b0, 12'h000, '0, "R4 manufacturer read");
        chk_tr(4, 1'b0, 12'h001, '0, "R4 device read");
        chk(id_manuf == 32'h00010001, "R4 manufacturer code", id_manuf, 32'h00010001);
        chk(id_dev == 32'h22F622F6, "R4 device code", id_dev, 32'h22F622F6);

        // R8 R9 erase with skips; one lane done early must not end the poll
        rsp_first = 32'h00800000; rsp_busy = 32'h00800000; rsp_nbusy = 1;
        rsp_final = 32'hFFFFFFFF;
        run_op(2'd2, '0, '0, 1, 5, 8'b0001_0100, 1'b0);
        chk(st == 0, "R9 erase status", 32'(st), 0);
        chk_tr(2, 1'b1, 12'h555, 32'h00800080, "R8 erase command");
        chk_tr(3, 1'b1, 12'h555, 32'h00AA00AA, "R8 second unlock a");
        chk_tr(4, 1'b1, 12'h2AA, 32'h00550055, "R8 second unlock b");
        chk_tr(5, 1'b1, 12'(1*SW), 32'h00300030, "R8 sector 1");
        chk_tr(6, 1'b1, 12'(3*SW), 32'h00300030, "R8 sector 3");
        chk_tr(7, 1'b1, 12'(5*SW), 32'h00300030, "R8 sector 5");
        chk_tr(8, 1'b0, 12'(5*SW), '0, "R9 poll last erased");
        chk(tr_n == 12, "R9 both lanes needed, access count", tr_n, 12);
        chk_tr(11, 1'b1, 12'h000, 32'h00F000F0, "R9 read-mode reset");
        chk(tr_cyc[8] - tr_cyc[7] >= SETTLE, "R9 settling gap", tr_cyc[8] - tr_cyc[7], SETTLE);

        // R10 all protected, with R13 request while busy ignored
        tr_n = 0; rd_k = 0;
        @(negedge clk);
        req_op = 2'd2; req_first = 2; req_last = 3; protect_mask = 8'b0000_1100;
        req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R13 busy during erase", 32'(busy), 1);
        req_op = 2'd1; req_addr = 12'h010; req_data = 32'h0; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        begin
            int g = 0;
            while (!done && g < 2000) begin @(negedge clk); g++; end
        end
        chk(status == 0, "R10 status", 32'(status), 0);
        begin
            int nd = 0;
            repeat (30) begin @(negedge clk); if (done) nd++; end
            chk(nd == 0, "R13 request during busy ignored", nd, 0);
        end
        chk(tr_n == 6, "R10 no sector write or poll", tr_n, 6);
        chk_tr(5, 1'b1, 12'h000, 32'h00F000F0, "R10 direct reset");

        // R11 erase timeout
        rsp_first = 32'h00000080; rsp_busy = 32'h00000080; rsp_nbusy = 1000;
        run_op(2'd2, '0, '0, 0, 0, '0, 1'b0);
        chk(st == 1, "R11 erase timeout status", 32'(st), 1);
        chk(tr_we[tr_n-1] == 1'b0, "R11 no reset write", 32'(tr_we[tr_n-1]), 0);

        // R12 invalid ranges
        run_op(2'd2, '0, '0, -1, 3, '0, 1'b0);
        chk(st == 1 && tr_n == 0, "R12 negative first", {st, 16'(tr_n)}, 32'h10000);
        run_op(2'd2, '0, '0, 4, 2, '0, 1'b0);
        chk(st == 1 && tr_n == 0, "R12 first above last", {st, 16'(tr_n)}, 32'h10000);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait (cyc > 150000);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule